// File: doc/BRIEF.md
# Square-Wave Tone Generator with Linear Envelope

This block produces a one-bit square tone and a matching 8-bit sample whose level follows an automatic linear envelope. A control agent sets the half-period, the start level, the ramp direction, the number of tone periods between level steps and the tone length in whole periods. It then pulses `start`. The block takes in all settings on that pulse and plays the tone with no further attention. When the programmed number of periods has elapsed, it stops and raises a sticky interrupt.

`enable` acts as a master gate. Dropping it silences both outputs in the same cycle and abandons the tone. The interrupt flag stays set until `irq_clr` is pulsed.

Top module: `tone_env_gen`

## Requirements
- R1: After reset, `tone_out` is 0, `sample_out` is 0 and `irq` is 0.
- R2: On the clock edge that samples `start` high with `enable` high, `tone_out` goes to 1. It then toggles every H clock cycles, where H is `half_period`; a value of 0 behaves as 1.
- R3: After L complete tone periods, where L is `tone_length`, the tone stops and `irq` rises exactly 2·H·L cycles after the start edge. For L = 0, `irq` rises on the start edge itself and no tone is produced.
- R4: `irq` stays high until `irq_clr` is sampled high, and it is low on the following cycle.
- R5: `amp_mode` selects the ramp: 1 = up, 2 = down, 0 or 3 = hold. After every S completed periods, where S is `step_interval` (0 behaves as 1), the level moves by one in the selected direction. The first period plays the level from `amp_init`.
- R6: The level saturates at 255 going up and at 0 going down, and never wraps.
- R7: `sample_out` equals the current level while `tone_out` is 1 and is 0 otherwise.
- R8: With `enable` low, `tone_out` and `sample_out` read 0 in the same cycle. The running tone is abandoned without an interrupt, and `start` has no effect.
- R9: A `start` during a running tone reloads all counters, so timing restarts from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Master gate for the tone |
| start | input | 1 | One-cycle pulse that captures settings and begins a tone |
| half_period | input | 16 | Half-period of the tone in clock cycles |
| amp_init | input | 8 | Starting level |
| amp_mode | input | 2 | Ramp direction (1 up, 2 down, else hold) |
| step_interval | input | 16 | Tone periods between level steps |
| tone_length | input | 16 | Tone length in complete periods |
| irq_clr | input | 1 | Write-one clear of the interrupt flag |
| tone_out | output | 1 | Square tone |
| sample_out | output | 8 | Level-scaled sample |
| irq | output | 1 | Sticky end-of-tone interrupt |

## Verification
A divider counter that drifts shifts every later edge. It therefore shows up as a wrong count of high cycles within the first period and as a late or early `irq`. A wrong level step count or a wrapped level appears on `sample_out` during the final high phase, at most one period after the fault. A length counter that is off by one moves `irq` by a whole period of 2·H cycles. Gating faults show in the same cycle that `enable` falls.

// File: rtl/tone_pkg.sv
// Shared types for the tone generator.
package tone_pkg;
    typedef enum logic [1:0] {
        RAMP_HOLD  = 2'd0,
        RAMP_UP    = 2'd1,
        RAMP_DOWN  = 2'd2,
        RAMP_HOLD3 = 2'd3
    } ramp_mode_e;
endpackage

// File: rtl/tone_divider.sv
// Half-period divider. On load it captures the half-period (0 taken as 1),
// sets the tone high and counts down; the tone toggles on each zero.
// Assumes load is only pulsed with run intended to follow.
module tone_divider #(
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          run,
    input  logic [HW-1:0] half_in,
    output logic          tone_q,
    output logic          period_end
);
    logic [HW-1:0] h_lat;
    logic [HW-1:0] cnt;
    logic [HW-1:0] h_eff;

    // Clamp a zero half-period to one cycle.
    always_comb h_eff = (half_in == '0) ? HW'(1) : half_in;

    // Count down the half-period and toggle the tone on each zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_lat  <= HW'(1);
            cnt    <= '0;
            tone_q <= 1'b0;
        end else if (load) begin
            h_lat  <= h_eff;
            cnt    <= h_eff - HW'(1);
            tone_q <= 1'b1;
        end else if (run) begin
            if (cnt == '0) begin
                cnt    <= h_lat - HW'(1);
                tone_q <= ~tone_q;
            end else begin
                cnt <= cnt - HW'(1);
            end
        end else begin
            tone_q <= 1'b0;
        end
    end

    // A period completes when the low half ends.
    always_comb period_end = run && !load && (cnt == '0) && !tone_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load) |-> (cnt < h_lat)); // R2
endmodule

// File: rtl/tone_envelope.sv
// Linear level envelope. On load it captures the start level, ramp mode and
// step interval (0 taken as 1). Every interval-th period end it moves the
// level by one, saturating at both ends.
module tone_envelope
    import tone_pkg::*;
#(
    parameter int AW = 8,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          period_end,
    input  logic [AW-1:0] amp_init,
    input  logic [1:0]    mode_in,
    input  logic [SW-1:0] interval,
    output logic [AW-1:0] amp
);
    localparam logic [AW-1:0] AMP_MAX = {AW{1'b1}};

    ramp_mode_e    mode_q;
    logic [SW-1:0] s_lat;
    logic [SW-1:0] s_cnt;
    logic [SW-1:0] s_eff;
    logic          step;

    // Clamp a zero interval to one period.
    always_comb s_eff = (interval == '0) ? SW'(1) : interval;
    // A step is due when the interval count runs out at a period end.
    always_comb step = period_end && !load && (s_cnt == SW'(1));

    // Track periods between steps and update the level with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= RAMP_HOLD;
            s_lat  <= SW'(1);
            s_cnt  <= SW'(1);
            amp    <= '0;
        end else if (load) begin
            mode_q <= ramp_mode_e'(mode_in);
            s_lat  <= s_eff;
            s_cnt  <= s_eff;
            amp    <= amp_init;
        end else if (period_end) begin
            if (s_cnt == SW'(1)) begin
                s_cnt <= s_lat;
                if (mode_q == RAMP_UP && amp != AMP_MAX)
                    amp <= amp + AW'(1);
                else if (mode_q == RAMP_DOWN && amp != '0)
                    amp <= amp - AW'(1);
            end else begin
                s_cnt <= s_cnt - SW'(1);
            end
        end
    end

    AST_AMP_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode_q == RAMP_UP && amp == AMP_MAX) |=> (amp == AMP_MAX)); // R6
    AST_AMP_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode_q == RAMP_DOWN && amp == '0) |=> (amp == '0)); // R6
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (mode_q == RAMP_HOLD || mode_q == RAMP_HOLD3)) |=> $stable(amp)); // R5
endmodule

// File: rtl/tone_length.sv
// Length counter in whole tone periods. Done fires on the last period end,
// or on the load itself when the length is zero.
module tone_length #(
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          period_end,
    input  logic [LW-1:0] len_in,
    output logic          done
);
    logic [LW-1:0] rem;

    // Load the length and count down one per completed period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rem <= '0;
        else if (load)
            rem <= len_in;
        else if (period_end && rem != '0)
            rem <= rem - LW'(1);
    end

    // Signal completion on the final period or a zero-length load.
    always_comb done = load ? (len_in == '0) : (period_end && rem == LW'(1));

    AST_REM_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && !load) |-> (rem != '0)); // R3
endmodule

// File: rtl/tone_env_gen.sv
// Top of the square tone generator with linear envelope and end-of-tone
// interrupt. Settings are captured on start; enable gates outputs
// combinationally and stops the tone on the next edge.
module tone_env_gen #(
    parameter int HW = 16,
    parameter int AW = 8,
    parameter int SW = 16,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          start,
    input  logic [HW-1:0] half_period,
    input  logic [AW-1:0] amp_init,
    input  logic [1:0]    amp_mode,
    input  logic [SW-1:0] step_interval,
    input  logic [LW-1:0] tone_length,
    input  logic          irq_clr,
    output logic          tone_out,
    output logic [AW-1:0] sample_out,
    output logic          irq
);
    logic          load;
    logic          active;
    logic          tone_q;
    logic          period_end;
    logic          done;
    logic [AW-1:0] amp;

    // Settings are only taken while enabled.
    always_comb load = start && enable;

    tone_divider #(.HW(HW)) div_i (
        .clk(clk), .rst_n(rst_n), .load(load), .run(active),
        .half_in(half_period), .tone_q(tone_q), .period_end(period_end)
    );

    tone_envelope #(.AW(AW), .SW(SW)) env_i (
        .clk(clk), .rst_n(rst_n), .load(load), .period_end(period_end),
        .amp_init(amp_init), .mode_in(amp_mode), .interval(step_interval),
        .amp(amp)
    );

    tone_length #(.LW(LW)) len_i (
        .clk(clk), .rst_n(rst_n), .load(load), .period_end(period_end),
        .len_in(tone_length), .done(done)
    );

    // Run state: begins on start, ends on done or when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= 1'b0;
        else if (!enable)
            active <= 1'b0;
        else if (start)
            active <= (tone_length != '0);
        else if (done)
            active <= 1'b0;
    end

    // Sticky interrupt: set on done, cleared by a write of one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (done)
            irq <= 1'b1;
        else if (irq_clr)
            irq <= 1'b0;
    end

    // Output gating and level scaling.
    always_comb begin
        tone_out   = tone_q && active && enable;
        sample_out = tone_out ? amp : '0;
    end

    AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> irq); // R3
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !done) |=> !irq); // R4
    AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !active); // R8
endmodule

// File: tb/tone_env_gen_tb_top.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module tone_env_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        start = 1'b0;
    logic [15:0] half_period = '0;
    logic [7:0]  amp_init = '0;
    logic [1:0]  amp_mode = '0;
    logic [15:0] step_interval = '0;
    logic [15:0] tone_length = '0;
    logic        irq_clr = 1'b0;
    logic        tone_out;
    logic [7:0]  sample_out;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    tone_env_gen dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
        .half_period(half_period), .amp_init(amp_init), .amp_mode(amp_mode),
        .step_interval(step_interval), .tone_length(tone_length),
        .irq_clr(irq_clr), .tone_out(tone_out), .sample_out(sample_out),
        .irq(irq)
    );

    // Vector table: half, length, start level, mode, interval.
    localparam int NV = 5;
    localparam int VH[NV] = '{3, 2, 1, 2, 1};
    localparam int VL[NV] = '{4, 5, 6, 4, 5};
    localparam int VA[NV] = '{100, 10, 3, 254, 1};
    localparam int VM[NV] = '{0, 1, 2, 1, 2};
    localparam int VS[NV] = '{1, 1, 2, 1, 0};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_level(int a, int m, int l, int s);
        int se = (s == 0) ? 1 : s;
        int st = (l >= 1) ? (l - 1) / se : 0;
        if (m == 1) return (a + st > 255) ? 255 : a + st;
        if (m == 2) return (a - st < 0) ? 0 : a - st;
        return a;
    endfunction

    // Start a tone and record irq time, high cycles, first/last level, gating errors.
    task automatic run_tone(input int h, input int l, input int a, input int m, input int s,
                            output int t_irq, output int highs, output int first_amp,
                            output int last_amp, output int bad_gate);
        @(negedge clk);
        half_period = 16'(h); tone_length = 16'(l); amp_init = 8'(a);
        amp_mode = 2'(m); step_interval = 16'(s); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t_irq = -1; highs = 0; first_amp = -1; last_amp = -1; bad_gate = 0;
        for (int idx = 0; idx < 3000; idx++) begin
            if (irq) begin
                t_irq = idx;
                break;
            end
            if (tone_out) begin
                highs++;
                if (first_amp < 0) first_amp = sample_out;
                last_amp = sample_out;
            end else if (sample_out != 0) begin
                bad_gate++;
            end
            @(negedge clk);
        end
    endtask

    task automatic clear_irq();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int t_irq, highs, fa, la, bg;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(tone_out == 1'b0, "R1 tone", int'(tone_out), 0);
        chk(sample_out == 8'd0, "R1 sample", int'(sample_out), 0);
        chk(irq == 1'b0, "R1 irq", int'(irq), 0);
        rst_n = 1'b1;
        enable = 1'b1;

        // Table walk: R2 timing, R3 length, R5/R6 envelope, R7 sample gating
        for (int v = 0; v < NV; v++) begin
            run_tone(VH[v], VL[v], VA[v], VM[v], VS[v], t_irq, highs, fa, la, bg);
            chk(highs == VH[v] * VL[v], "R2 high cycles", highs, VH[v] * VL[v]);
            chk(t_irq == 2 * VH[v] * VL[v], "R3 irq time", t_irq, 2 * VH[v] * VL[v]);
            chk(fa == VA[v], "R5 first level", fa, VA[v]);
            chk(la == exp_level(VA[v], VM[v], VL[v], VS[v]), "R5 R6 last level", la,
                exp_level(VA[v], VM[v], VL[v], VS[v]));
            chk(bg == 0, "R7 sample zero when low", bg, 0);
            @(negedge clk);
            chk(tone_out == 1'b0, "R3 tone stopped", int'(tone_out), 0);
            chk(irq == 1'b1, "R4 irq sticky", int'(irq), 1);
            clear_irq();
            chk(irq == 1'b0, "R4 irq cleared", int'(irq), 0);
        end

        // R2: zero half-period behaves as one
        run_tone(0, 2, 5, 0, 1, t_irq, highs, fa, la, bg);
        chk(t_irq == 4, "R2 zero half irq", t_irq, 4);
        chk(highs == 2, "R2 zero half highs", highs, 2);
        clear_irq();

        // R3: zero length raises irq on the start edge with no tone
        run_tone(3, 0, 5, 0, 1, t_irq, highs, fa, la, bg);
        chk(t_irq == 0, "R3 zero length irq", t_irq, 0);
        chk(highs == 0, "R3 zero length highs", highs, 0);
        clear_irq();

        // R9: restart mid-tone reloads counters
        @(negedge clk);
        half_period = 16'd2; tone_length = 16'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        run_tone(2, 3, 20, 0, 1, t_irq, highs, fa, la, bg);
        chk(t_irq == 12, "R9 restart irq time", t_irq, 12);
        chk(highs == 6, "R9 restart highs", highs, 6);
        clear_irq();

        // R8: disabling mid-tone silences outputs at once, no irq
        @(negedge clk);
        half_period = 16'd4; tone_length = 16'd10; amp_init = 8'd77;
        amp_mode = 2'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        chk(tone_out == 1'b1, "R8 tone before disable", int'(tone_out), 1);
        enable = 1'b0;
        #1;
        chk(tone_out == 1'b0, "R8 tone gated", int'(tone_out), 0);
        chk(sample_out == 8'd0, "R8 sample gated", int'(sample_out), 0);
        repeat (100) @(negedge clk);
        chk(irq == 1'b0, "R8 no irq after abandon", int'(irq), 0);
        // R8: start ignored while disabled
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        enable = 1'b1;
        #1;
        chk(tone_out == 1'b0, "R8 start ignored tone", int'(tone_out), 0);
        repeat (100) @(negedge clk);
        chk(irq == 1'b0, "R8 start ignored irq", int'(irq), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule